// File: doc/BRIEF.md
# Serial Fuse Row Target

This block stands in for the device side of a serial fuse programming interface, so that a programmer design can be tested against synthesizable logic. It holds an array of 40-bit logic rows and a set of special rows. One 6-bit row address selects any of them. A single serial register takes data in on each rising edge of a serial clock. It also shifts stored data back out. A strobe commits or fetches the addressed row, and a mode input decides which of the two happens.

All serial inputs are synchronous to the system clock `clk`. Rising edges of the serial clock and of the strobe are found by comparing each input with its value one cycle earlier. A strobe takes two system cycles to complete: one to read the row storage and one to update it or to load the serial register.

The length of the serial register depends on the address. Logic rows, the signature row and unmapped addresses use 40 bits. The architecture word uses 82 bits. The three control rows use one bit each: lock, spare and erase. Fuse bits follow a one-time rule: programming can only clear bits, and only a bulk erase sets them back to one. A lock bit hides the row contents from read-back.

Top module: `fuse_row_target`

## Requirements
- R1: After a synchronous reset, the block is in a blank state: every logic row and the architecture word read back as all ones, the lock and spare bits read 0, and `sdout` is 0.
- R2: Each rising edge of `sclk` moves the serial register one place toward bit 0. `sdin` enters at the top bit of the active length, and `sdout` always shows bit 0. After a full-length shift, the first bit shifted in sits at word bit 0. Shifting that many more bits brings the word out on `sdout` in the same order.
- R3: The active length is 40 bits for addresses 0–59 except 60. It is 82 bits at address 60 and 1 bit at addresses 61, 62 and 63. In a 1-bit row, only the last bit shifted in counts.
- R4: A rising `strobe` edge with `prog`=1 at a logic row address (0–31) ANDs the 40-bit shifted word into that row.
- R5: A rising `strobe` edge with `prog`=0 loads the addressed row into the serial register within two `clk` cycles. Word bit 0 then appears on `sdout` before any further `sclk` edge.
- R6: The architecture word at address 60 is programmed by AND and read back over its full 82 bits.
- R7: Address 32 reads back the constant signature parameter. Programming address 32 has no effect.
- R8: Programming a 1 at address 61 sets the lock bit. While the lock bit is set, a read-back of a logic row or of the architecture word returns all ones. Address 61 itself reads back 1. Programming a 0 at address 61 leaves the lock bit as it was.
- R9: Programming a 1 at address 63 sets every logic row and the architecture word to all ones and clears the lock bit. Programming a 0 there does nothing, and the spare bit is not touched.
- R10: Address 62 stores the last programmed bit as it is written and reads it back.
- R11: Addresses 33–59 and address 63 read back as zero, and programming addresses 33–59 changes no stored row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to the blank state |
| sclk | input | 1 | Serial shift clock, sampled by `clk` |
| sdin | input | 1 | Serial data in |
| strobe | input | 1 | Commit or fetch request, acted on at its rising edge |
| prog | input | 1 | 1 = program the addressed row, 0 = load it for read-back |
| row_addr | input | 6 | Row address |
| sdout | output | 1 | Serial data out, bit 0 of the serial register |

## Verification
The bench builds the block with its default parameters: 32 logic rows of 40 bits, an 82-bit architecture word, and the signature at address 32. With these values the random phase can reach every logic row and every bit of the architecture word. It can also check a shift register that is wider than any 64-bit quantity. The directed cases cover the 1-bit rows, the lock masking and a bulk erase after earlier AND-programming. In these cases, stored bits must come back to one.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  typedef enum logic [2:0] {
    CLS_LOGIC,
    CLS_SIG,
    CLS_ARCH,
    CLS_LOCK,
    CLS_SPARE,
    CLS_ERASE,
    CLS_NONE
  } row_cls_e;

  typedef enum logic [1:0] {
    LEN_ROW,
    LEN_ARCH,
    LEN_BIT
  } len_e;

  // Map a row address onto the class of row it reaches.
  function automatic row_cls_e classify(input int a, input int n_rows,
                                        input int sig_a, input int arch_a,
                                        input int lock_a, input int spare_a,
                                        input int erase_a);
    row_cls_e c;
    if (a < n_rows)        c = CLS_LOGIC;
    else if (a == sig_a)   c = CLS_SIG;
    else if (a == arch_a)  c = CLS_ARCH;
    else if (a == lock_a)  c = CLS_LOCK;
    else if (a == spare_a) c = CLS_SPARE;
    else if (a == erase_a) c = CLS_ERASE;
    else                   c = CLS_NONE;
    return c;
  endfunction

  // Active serial length that goes with each class.
  function automatic len_e len_of(input row_cls_e c);
    len_e l;
    case (c)
      CLS_ARCH:                        l = LEN_ARCH;
      CLS_LOCK, CLS_SPARE, CLS_ERASE:  l = LEN_BIT;
      default:                         l = LEN_ROW;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/rise_det.sv
module rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/fuse_shift.sv
module fuse_shift
  import fuse_pkg::*;
#(
  parameter int W     = 82,
  parameter int ROW_W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sdin,
  input  len_e         len_sel,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  int top_idx;

  always_comb begin
    case (len_sel)
      LEN_ARCH: top_idx = W - 1;
      LEN_BIT:  top_idx = 0;
      default:  top_idx = ROW_W - 1;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic up;
    if (i == W - 1) begin : g_top
      assign up = sdin;
    end else begin : g_mid
      assign up = q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else if (load_en) begin
        q[i] <= load_val[i];
      end else if (shift_en) begin
        if (i == top_idx)     q[i] <= sdin;
        else if (i < top_idx) q[i] <= up;
      end
    end
  end
endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int ROW_W  = 40,
  parameter int N_ROWS = 32,
  localparam int IDX_W = $clog2(N_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [ROW_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ROW_W-1:0] wr_data,
  input  logic             erase_all
);
  logic [ROW_W-1:0]  mem [N_ROWS];
  logic [N_ROWS-1:0] blank_q;
  logic [ROW_W-1:0]  mem_q;
  logic              blank_rd_q;

  // Plain synchronous write and read ports, suited to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) mem_q <= mem[rd_addr];
  end

  // Per-row blank flags let a bulk erase finish in a single cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q    <= '1;
      blank_rd_q <= 1'b1;
    end else begin
      if (erase_all)  blank_q <= '1;
      else if (wr_en) blank_q[wr_addr] <= 1'b0;
      if (rd_en)      blank_rd_q <= blank_q[rd_addr];
    end
  end

  assign rd_data = blank_rd_q ? '1 : mem_q;
endmodule

// File: rtl/fuse_row_target.sv
module fuse_row_target
  import fuse_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int ROW_W      = 40,
  parameter int N_ROWS     = 32,
  parameter int ARCH_W     = 82,
  parameter int SIG_ADDR   = 32,
  parameter int ARCH_ADDR  = 60,
  parameter int LOCK_ADDR  = 61,
  parameter int SPARE_ADDR = 62,
  parameter int ERASE_ADDR = 63,
  parameter logic [ROW_W-1:0] SIG_VALUE = 40'hA5_3C96_1E87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              strobe,
  input  logic              prog,
  input  logic [ADDR_W-1:0] row_addr,
  output logic              sdout
);
  localparam int IDX_W = $clog2(N_ROWS);
  localparam int PAD_W = ARCH_W - ROW_W;

  logic sclk_rise, str_rise;
  row_cls_e cur_cls, op_cls;
  logic op_pend, op_prog;
  logic [IDX_W-1:0] op_idx;
  logic [ARCH_W-1:0] sr_q, arch_q, sr_load_val;
  logic sr_load, lock_q, spare_q;
  logic [ROW_W-1:0] st_rd, st_wr_data;
  logic st_wr_en, st_erase, do_erase;

  rise_det u_sclk_edge (.clk(clk), .rst(rst), .din(sclk),   .rise(sclk_rise));
  rise_det u_str_edge  (.clk(clk), .rst(rst), .din(strobe), .rise(str_rise));

  assign cur_cls = classify(int'(row_addr), N_ROWS, SIG_ADDR, ARCH_ADDR,
                            LOCK_ADDR, SPARE_ADDR, ERASE_ADDR);

  fuse_shift #(.W(ARCH_W), .ROW_W(ROW_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .sdin(sdin),
    .len_sel(len_of(cur_cls)), .load_en(sr_load), .load_val(sr_load_val),
    .q(sr_q)
  );

  fuse_store #(.ROW_W(ROW_W), .N_ROWS(N_ROWS)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(str_rise && cur_cls == CLS_LOGIC),
    .rd_addr(row_addr[IDX_W-1:0]), .rd_data(st_rd),
    .wr_en(st_wr_en), .wr_addr(op_idx), .wr_data(st_wr_data),
    .erase_all(st_erase)
  );

  // First stroke cycle: latch the request while the store reads.
  always_ff @(posedge clk) begin
    if (rst) begin
      op_pend <= 1'b0;
      op_prog <= 1'b0;
      op_cls  <= CLS_NONE;
      op_idx  <= '0;
    end else begin
      op_pend <= str_rise;
      if (str_rise) begin
        op_prog <= prog;
        op_cls  <= cur_cls;
        op_idx  <= row_addr[IDX_W-1:0];
      end
    end
  end

  assign do_erase = op_pend && op_prog && op_cls == CLS_ERASE && sr_q[0];

  // Second stroke cycle: program the row or fetch it for read-back.
  always_comb begin
    st_wr_en    = 1'b0;
    st_wr_data  = st_rd & sr_q[ROW_W-1:0];
    st_erase    = do_erase;
    sr_load     = 1'b0;
    sr_load_val = '0;
    if (op_pend && op_prog) begin
      st_wr_en = (op_cls == CLS_LOGIC);
    end else if (op_pend) begin
      sr_load = 1'b1;
      case (op_cls)
        CLS_LOGIC: sr_load_val = lock_q ? '1 : {{PAD_W{1'b0}}, st_rd};
        CLS_SIG:   sr_load_val = {{PAD_W{1'b0}}, SIG_VALUE};
        CLS_ARCH:  sr_load_val = lock_q ? '1 : arch_q;
        CLS_LOCK:  sr_load_val = {{(ARCH_W-1){1'b0}}, lock_q};
        CLS_SPARE: sr_load_val = {{(ARCH_W-1){1'b0}}, spare_q};
        default:   sr_load_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arch_q  <= '1;
      lock_q  <= 1'b0;
      spare_q <= 1'b0;
    end else if (do_erase) begin
      arch_q  <= '1;
      lock_q  <= 1'b0;
    end else if (op_pend && op_prog) begin
      case (op_cls)
        CLS_ARCH:  arch_q  <= arch_q & sr_q;
        CLS_LOCK:  lock_q  <= lock_q | sr_q[0];
        CLS_SPARE: spare_q <= sr_q[0];
        default:   ;
      endcase
    end
  end

  assign sdout = sr_q[0];
endmodule

// File: rtl/fuse_row_target_chk.sv
module fuse_row_target_chk
  import fuse_pkg::*;
#(
  parameter int ARCH_W = 82
) (
  input logic              clk,
  input logic              rst,
  input logic              sdin,
  input logic              sdout,
  input logic              sclk_rise,
  input logic              op_pend,
  input logic              op_prog,
  input row_cls_e          op_cls,
  input row_cls_e          cur_cls,
  input logic [ARCH_W-1:0] sr_q,
  input logic [ARCH_W-1:0] arch_q,
  input logic              lock_q
);
  logic erase_go;
  assign erase_go = op_pend && op_prog && op_cls == CLS_ERASE && sr_q[0];

  AST_RESET_BLANK: assert property (@(posedge clk)
    rst |=> (!lock_q && arch_q == '1 && !sdout)); // R1

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !op_pend && cur_cls == CLS_ARCH) |=> sr_q[0] == $past(sr_q[1])); // R2

  AST_BIT_ROW_LEN: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !op_pend && cur_cls == CLS_SPARE) |=> sdout == $past(sdin)); // R3

  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (rst)
    op_pend |=> !op_pend); // R5

  AST_ARCH_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !erase_go |=> ((arch_q & ~$past(arch_q)) == '0)); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !erase_go) |=> lock_q); // R8

  AST_LOCK_MASKS: assert property (@(posedge clk) disable iff (rst)
    (op_pend && !op_prog && lock_q && op_cls == CLS_ARCH) |=> sr_q == '1); // R8

  AST_ERASE_BLANKS: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> (!lock_q && arch_q == '1)); // R9
endmodule

bind fuse_row_target fuse_row_target_chk #(.ARCH_W(ARCH_W)) u_chk (
  .clk(clk), .rst(rst), .sdin(sdin), .sdout(sdout), .sclk_rise(sclk_rise),
  .op_pend(op_pend), .op_prog(op_prog), .op_cls(op_cls), .cur_cls(cur_cls),
  .sr_q(sr_q), .arch_q(arch_q), .lock_q(lock_q)
);

// File: tb/sim_fuse_row_target.sv
module sim_fuse_row_target;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 40;
  localparam int AW = 82;
  localparam int NR = 32;
  localparam logic [RW-1:0] SIG = 40'hA5_3C96_1E87;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdin = 1'b0, strobe = 1'b0, prog = 1'b0;
  logic [5:0] row_addr = '0;
  logic sdout;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [RW-1:0] ref_rows [NR];
  logic [AW-1:0] ref_arch;
  logic ref_lock, ref_spare;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_row_target u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .strobe(strobe),
    .prog(prog), .row_addr(row_addr), .sdout(sdout)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdin = b; sclk = 1'b1; tick(2);
    sclk = 1'b0; tick(2);
  endtask

  task automatic pulse_str(input logic p, input logic [5:0] a);
    row_addr = a; prog = p; strobe = 1'b1; tick(2);
    strobe = 1'b0; tick(2);
  endtask

  task automatic write_row(input logic [5:0] a, input logic [AW-1:0] w, input int len);
    row_addr = a;
    for (int i = 0; i < len; i++) put_bit(w[i]);
    pulse_str(1'b1, a);
  endtask

  task automatic read_row(input logic [5:0] a, input int len, output logic [AW-1:0] got);
    pulse_str(1'b0, a);
    got = '0;
    for (int i = 0; i < len; i++) begin
      got[i] = sdout;
      put_bit(1'b0);
    end
  endtask

  task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_row(input int idx);
    return ref_lock ? {{(AW-RW){1'b0}}, {RW{1'b1}}} : {{(AW-RW){1'b0}}, ref_rows[idx]};
  endfunction

  function automatic logic [AW-1:0] exp_arch();
    return ref_lock ? {AW{1'b1}} : ref_arch;
  endfunction

  function automatic logic [AW-1:0] rnd_word();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[AW-1:0];
  endfunction

  task automatic blank_model();
    for (int i = 0; i < NR; i++) ref_rows[i] = '1;
    ref_arch = '1;
    ref_lock = 1'b0;
  endtask

  task automatic random_ops(input int n);
    logic [AW-1:0] w, got;
    int a;
    for (int k = 0; k < n; k++) begin
      a = int'($urandom_range(NR - 1));
      case ($urandom_range(3))
        0: begin
          w = rnd_word() | rnd_word();
          write_row(6'(a), w, RW);
          ref_rows[a] = ref_rows[a] & w[RW-1:0];
        end
        1: begin
          read_row(6'(a), RW, got);
          check("R4 random row", got, exp_row(a));
        end
        2: begin
          w = rnd_word() | rnd_word() | rnd_word();
          write_row(6'd60, w, AW);
          ref_arch = ref_arch & w;
        end
        default: begin
          read_row(6'd60, AW, got);
          check("R6 random arch", got, exp_arch());
        end
      endcase
    end
  endtask

  initial begin
    logic [AW-1:0] got, w;
    void'($urandom(32'd4711));
    blank_model();
    ref_spare = 1'b0;
    tick(5);
    rst = 1'b0;
    tick(2);
    check("R1 sdout after reset", {{(AW-1){1'b0}}, sdout}, '0);
    read_row(6'd0, RW, got);  check("R1 row 0 blank", got, exp_row(0));
    read_row(6'd31, RW, got); check("R1 row 31 blank", got, exp_row(31));
    read_row(6'd60, AW, got); check("R1 arch blank", got, {AW{1'b1}});
    read_row(6'd61, 1, got);  check("R1 lock clear", got, '0);
    read_row(6'd62, 1, got);  check("R1 spare clear", got, '0);

    // R2: plain shift through an unmapped 40-bit address
    w = rnd_word();
    row_addr = 6'd40;
    for (int i = 0; i < RW; i++) put_bit(w[i]);
    got = '0;
    for (int i = 0; i < RW; i++) begin got[i] = sdout; put_bit(1'b0); end
    check("R2 shift order", got, {{(AW-RW){1'b0}}, w[RW-1:0]});

    // R11: unmapped and erase rows read zero; unmapped write ignored
    write_row(6'd45, '0, RW);
    read_row(6'd45, RW, got); check("R11 unmapped read", got, '0);
    read_row(6'd63, 1, got);  check("R11 erase row read", got, '0);
    read_row(6'd13, RW, got); check("R11 rows untouched", got, exp_row(13));

    // R4 / R5: AND programming and load timing
    write_row(6'd5, {42'd0, 40'hF0F0_FF00_AA}, RW);
    ref_rows[5] = ref_rows[5] & 40'hF0F0_FF00_AA;
    write_row(6'd5, {42'd0, 40'h3C3C_F0F0_FF}, RW);
    ref_rows[5] = ref_rows[5] & 40'h3C3C_F0F0_FF;
    read_row(6'd5, RW, got); check("R4 AND program", got, exp_row(5));
    pulse_str(1'b0, 6'd5);
    check("R5 first bit before shift", {{(AW-1){1'b0}}, sdout}, {{(AW-1){1'b0}}, ref_rows[5][0]});

    // R6 / R3: full-width architecture word, top bit cleared
    w = {1'b0, {(AW-1){1'b1}}} & rnd_word() | {1'b0, 1'b1, {(AW-2){1'b0}}};
    write_row(6'd60, w, AW);
    ref_arch = ref_arch & w;
    read_row(6'd60, AW, got); check("R6 R3 arch 82 bits", got, exp_arch());

    // R7: signature fixed, writes ignored
    read_row(6'd32, RW, got); check("R7 signature", got, {{(AW-RW){1'b0}}, SIG});
    write_row(6'd32, '0, RW);
    read_row(6'd32, RW, got); check("R7 signature after write", got, {{(AW-RW){1'b0}}, SIG});

    // R10 / R3: 1-bit rows keep only the last bit shifted
    row_addr = 6'd62; put_bit(1'b0); put_bit(1'b1); pulse_str(1'b1, 6'd62);
    ref_spare = 1'b1;
    read_row(6'd62, 1, got); check("R10 spare set", got, {{(AW-1){1'b0}}, ref_spare});
    row_addr = 6'd61; put_bit(1'b1); put_bit(1'b0); pulse_str(1'b1, 6'd61);
    read_row(6'd61, 1, got); check("R3 lock last bit only", got, '0);

    random_ops(120);

    // R8: lock masks read-back and cannot be cleared by writing 0
    write_row(6'd61, {{(AW-1){1'b0}}, 1'b1}, 1);
    ref_lock = 1'b1;
    read_row(6'd61, 1, got);  check("R8 lock reads 1", got, {{(AW-1){1'b0}}, 1'b1});
    read_row(6'd5, RW, got);  check("R8 locked row", got, exp_row(5));
    read_row(6'd60, AW, got); check("R8 locked arch", got, exp_arch());
    write_row(6'd61, '0, 1);
    read_row(6'd61, 1, got);  check("R8 lock sticky", got, {{(AW-1){1'b0}}, 1'b1});

    // R9: erase with 0 does nothing, erase with 1 blanks
    write_row(6'd63, '0, 1);
    read_row(6'd61, 1, got);  check("R9 erase 0 ignored", got, {{(AW-1){1'b0}}, 1'b1});
    write_row(6'd63, {{(AW-1){1'b0}}, 1'b1}, 1);
    blank_model();
    read_row(6'd61, 1, got);  check("R9 lock cleared", got, '0);
    read_row(6'd5, RW, got);  check("R9 row blank", got, exp_row(5));
    read_row(6'd60, AW, got); check("R9 arch blank", got, exp_arch());
    read_row(6'd62, 1, got);  check("R9 R10 spare kept", got, {{(AW-1){1'b0}}, ref_spare});

    random_ops(40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule